// File: doc/BRIEF.md
# Serial Event Readout Sequencer

This block drains latched event data from a chain of up to sixteen front-end boards over one shared serial link. In hardware mode, a rising edge on the event-frame control bit starts a burst: a readout clock with a 50% duty cycle runs at the reference rate divided by a programmable divisor, for a preset total number of pulses. A 4-bit board address steps to the next board each time a programmable number of bits per board has been clocked. An optional 8-bit sync word is shifted out on a separate line, most significant bit first, at the start of the burst.

In software mode, the automatic sequencer is bypassed. The readout clock follows a register bit, and the board address follows the common-address register, so a driver can step through a readout by hand. The receiving side samples data on the rising edge of the readout clock, and the boards shift their next bit on the falling edge. For that reason the address and the sync-word bit change only on falling edges.

Top module: `evt_readout_seq`

## Requirements
- R1: After reset, with hardware mode on, `busy`, `rd_clk` and `pat_out` are 0.
- R2: A burst starts on the clock edge at which `frame` is 1, `frame` was 0 at the previous edge, `hw_en` is 1, `busy` is 0 and `total_bits` is nonzero. `mode` always equals `frame`, where 1 means event and 0 means monitor.
- R3: During a burst, `rd_clk` starts low. Each level lasts H reference cycles, where H = `div`/2 (integer division), or H = 1 when `div` is below 2.
- R4: `busy` stays 1 until the falling edge of the `total_bits`-th readout pulse, then drops with `rd_clk` low. In hardware mode, `rd_clk` is low whenever the block is not busy.
- R5: At burst start, `brd_addr` loads `base_addr`. It increments by one, modulo 16, after every `board_bits` falling edges. When `board_bits` is 0 the address never advances.
- R6: With `tp_en` high, `pat_out` carries bit 7 of the pattern captured at start until the first falling edge. It then carries bit 6, and so on down to bit 0. After eight falling edges `pat_out` is 0. With `tp_en` low, or when idle, `pat_out` is 0.
- R7: With `hw_en` low, `rd_clk` equals `sw_clk`, `brd_addr` equals `base_addr`, `pat_out` is 0, and no burst can start.
- R8: Driving `hw_en` low during a burst clears `busy` at the next clock edge and ends the burst.
- R9: `div`, `total_bits`, `board_bits`, `base_addr` and `tp_data` are captured at start. Changing them, or raising `frame` again, during a burst has no effect on that burst.
- R10: In hardware mode while idle, `brd_addr` follows `base_addr`.
- R11: A rising `frame` with `total_bits` equal to 0 starts no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz reference clock |
| rst_n | input | 1 | Active-low reset |
| hw_en | input | 1 | 1 = hardware readout, 0 = software mode |
| frame | input | 1 | Event-frame bit; its rising edge starts a burst |
| tp_en | input | 1 | Enables the serial sync word |
| tp_data | input | 8 | Sync word |
| sw_clk | input | 1 | Readout clock level in software mode |
| base_addr | input | 4 | Event common address |
| div | input | 16 | Readout clock divisor |
| total_bits | input | 16 | Readout pulses per event |
| board_bits | input | 16 | Bits per front-end board |
| rd_clk | output | 1 | Readout clock to the boards |
| brd_addr | output | 4 | Selected board address |
| pat_out | output | 1 | Serial sync-word line |
| mode | output | 1 | Event (1) or monitor (0) |
| busy | output | 1 | Burst in progress |

## Verification
The bench checks every output against its model on every cycle, so an internal fault shows at the ports as soon as it occurs.

- A corrupted phase counter shifts the next `rd_clk` edge within one half period.
- A wrong bit counter moves the `brd_addr` step to the wrong falling edge, or moves the drop of `busy`.
- A wrong captured pattern, or a wrong shift, shows on `pat_out` during the first eight readout pulses.

// File: rtl/evt_readout_seq.sv
module evt_readout_seq #(
  parameter int DIV_W  = 16,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4,
  parameter int PAT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_en,
  input  logic              frame,
  input  logic              tp_en,
  input  logic [PAT_W-1:0]  tp_data,
  input  logic              sw_clk,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [DIV_W-1:0]  div,
  input  logic [CNT_W-1:0]  total_bits,
  input  logic [CNT_W-1:0]  board_bits,
  output logic              rd_clk,
  output logic [ADDR_W-1:0] brd_addr,
  output logic              pat_out,
  output logic              mode,
  output logic              busy
);
  logic              frame_q, busy_q, clk_q;
  logic [DIV_W-1:0]  half_l, ph;
  logic [CNT_W-1:0]  total_l, board_l, fall_cnt, brd_cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [PAT_W-1:0]  pat_sh;

  wire start = hw_en & frame & ~frame_q & ~busy_q & (total_bits != '0);
  wire [DIV_W-1:0] half_in = (div < DIV_W'(2)) ? DIV_W'(1) : {1'b0, div[DIV_W-1:1]};
  wire tick = (ph == half_l - DIV_W'(1));
  wire last = (fall_cnt + CNT_W'(1) == total_l);
  wire brd_done = (board_l != '0) && (brd_cnt + CNT_W'(1) == board_l);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q  <= 1'b0;
      busy_q   <= 1'b0;
      clk_q    <= 1'b0;
      half_l   <= DIV_W'(1);
      ph       <= '0;
      total_l  <= '0;
      board_l  <= '0;
      fall_cnt <= '0;
      brd_cnt  <= '0;
      addr_q   <= '0;
      pat_sh   <= '0;
    end else begin
      frame_q <= frame;
      if (!hw_en) begin
        busy_q <= 1'b0;
        clk_q  <= 1'b0;
      end else if (start) begin
        busy_q   <= 1'b1;
        clk_q    <= 1'b0;
        ph       <= '0;
        half_l   <= half_in;
        total_l  <= total_bits;
        board_l  <= board_bits;
        fall_cnt <= '0;
        brd_cnt  <= '0;
        addr_q   <= base_addr;
        pat_sh   <= tp_data;
      end else if (busy_q) begin
        if (tick) begin
          ph    <= '0;
          clk_q <= ~clk_q;
          if (clk_q) begin
            fall_cnt <= fall_cnt + CNT_W'(1);
            pat_sh   <= pat_sh << 1;
            if (brd_done) begin
              brd_cnt <= '0;
              addr_q  <= addr_q + ADDR_W'(1);
            end else begin
              brd_cnt <= brd_cnt + CNT_W'(1);
            end
            if (last) busy_q <= 1'b0;
          end
        end else begin
          ph <= ph + DIV_W'(1);
        end
      end
    end
  end

  assign rd_clk   = hw_en ? clk_q : sw_clk;
  assign brd_addr = (hw_en & busy_q) ? addr_q : base_addr;
  assign pat_out  = hw_en & busy_q & tp_en & pat_sh[PAT_W-1];
  assign mode     = frame;
  assign busy     = busy_q;
endmodule

module evt_readout_seq_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hw_en,
  input logic              frame,
  input logic              sw_clk,
  input logic [ADDR_W-1:0] base_addr,
  input logic              rd_clk,
  input logic [ADDR_W-1:0] brd_addr,
  input logic              pat_out,
  input logic              busy
);
  assert_idle_clk_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_en && !busy) |-> !rd_clk);

  assert_start_on_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(frame) && $past(hw_en)));

  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_en |=> !busy);

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && hw_en && $past(hw_en) && brd_addr != $past(brd_addr))
      |-> brd_addr == ADDR_W'($past(brd_addr) + 1'b1));

  assert_pat_only_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pat_out |-> (busy && hw_en));

  assert_sw_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_en |-> (rd_clk == sw_clk && brd_addr == base_addr && !pat_out));
endmodule

bind evt_readout_seq evt_readout_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .frame(frame), .sw_clk(sw_clk),
  .base_addr(base_addr), .rd_clk(rd_clk), .brd_addr(brd_addr),
  .pat_out(pat_out), .busy(busy)
);

// File: tb/evt_readout_seq_test.sv
`timescale 1ns/100ps
module evt_readout_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hw_en = 1'b1, frame = 1'b0, tp_en = 1'b0, sw_clk = 1'b0;
  logic [7:0]  tp_data = 8'h00;
  logic [3:0]  base_addr = 4'h0;
  logic [15:0] div = 16'd4, total_bits = 16'd0, board_bits = 16'd48;
  logic rd_clk, pat_out, mode, busy;
  logic [3:0] brd_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  bit mb, pf;
  longint t, mhalf, mtot, mbb;
  logic [3:0] mbase;
  logic [7:0] mpat;

  always #2.5 clk = ~clk;

  evt_readout_seq uut (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .frame(frame), .tp_en(tp_en),
    .tp_data(tp_data), .sw_clk(sw_clk), .base_addr(base_addr), .div(div),
    .total_bits(total_bits), .board_bits(board_bits), .rd_clk(rd_clk),
    .brd_addr(brd_addr), .pat_out(pat_out), .mode(mode), .busy(busy)
  );

  task automatic model_upd();
    if (!rst_n) begin
      mb = 0; pf = 0;
    end else begin
      if (!hw_en) mb = 0;
      else if (mb) begin
        t++;
        if (t == 2 * mhalf * mtot) mb = 0;
      end else if (frame && !pf && total_bits != 0) begin
        mb = 1; t = 0;
        mhalf = (div < 2) ? 1 : longint'(div / 2);
        mtot = total_bits; mbb = board_bits; mbase = base_addr; mpat = tp_data;
      end
      pf = frame;
    end
  endtask

  task automatic chk(string tag, string sig, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, sig, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    longint falls, e_clk, e_addr, e_pat;
    falls = mb ? t / (2 * mhalf) : 0;
    e_clk = hw_en ? (mb ? (t / mhalf) % 2 : 0) : longint'(sw_clk);
    e_addr = (hw_en && mb) ? ((mbb == 0) ? longint'(mbase) : (longint'(mbase) + falls / mbb) % 16)
                           : longint'(base_addr);
    e_pat = (hw_en && mb && tp_en && falls < 8) ? longint'(mpat[7 - falls]) : 0;
    chk(tag, "rd_clk(R3)", rd_clk, e_clk);
    chk(tag, "brd_addr(R5)", brd_addr, e_addr);
    chk(tag, "pat_out(R6)", pat_out, e_pat);
    chk(tag, "busy(R4)", busy, longint'(mb));
    chk(tag, "mode(R2)", mode, frame);
  endtask

  task automatic cyc(string tag, int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 model_upd();
      @(negedge clk); compare(tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end

  initial begin
    model_upd();
    repeat (3) @(negedge clk);
    chk("R1 reset", "busy", busy, 0);
    chk("R1 reset", "rd_clk", rd_clk, 0);
    chk("R1 reset", "pat_out", pat_out, 0);
    rst_n = 1'b1;
    cyc("R1 idle", 3);

    // R10: idle address follows base
    base_addr = 4'd9; cyc("R10 idle addr", 2);
    chk("R10", "brd_addr", brd_addr, 9);

    // Wrap of address, pattern, half=2
    div = 16'd4; total_bits = 16'd10; board_bits = 16'd3; base_addr = 4'd14;
    tp_en = 1'b1; tp_data = 8'hA5;
    frame = 1'b1; cyc("R2 R5 R6 wrap", 45);
    chk("R4 end", "busy", busy, 0);
    frame = 1'b0; cyc("R4 idle", 3);

    // Odd divisor, no address advance, pattern off
    div = 16'd7; total_bits = 16'd5; board_bits = 16'd0; base_addr = 4'd3;
    tp_en = 1'b0; tp_data = 8'hFF;
    frame = 1'b1; cyc("R3 odd div", 35);
    frame = 1'b0; cyc("R3 idle", 2);

    // div below 2, pattern 0x3C
    div = 16'd1; total_bits = 16'd12; board_bits = 16'd4; base_addr = 4'd0;
    tp_en = 1'b1; tp_data = 8'h3C;
    frame = 1'b1; cyc("R3 R6 div1", 30);
    frame = 1'b0; cyc("R6 idle", 2);

    // R9: changes mid-burst ignored
    div = 16'd2; total_bits = 16'd8; board_bits = 16'd2; base_addr = 4'd5; tp_data = 8'h81;
    frame = 1'b1; cyc("R9 start", 4);
    div = 16'd10; total_bits = 16'd2; board_bits = 16'd1; base_addr = 4'd12; tp_data = 8'h00;
    frame = 1'b0; cyc("R9 change", 2);
    frame = 1'b1; cyc("R9 refire", 15);
    chk("R9 end", "busy", busy, 0);
    frame = 1'b0; cyc("R10 after", 2);

    // R8: abort
    div = 16'd6; total_bits = 16'd50; base_addr = 4'd7;
    frame = 1'b1; cyc("R8 start", 10);
    hw_en = 1'b0; cyc("R8 abort", 1);
    chk("R8", "busy", busy, 0);

    // R7: software mode
    frame = 1'b0; cyc("R7 sw", 1);
    frame = 1'b1; sw_clk = 1'b1; base_addr = 4'd2; cyc("R7 sw", 2);
    chk("R7", "rd_clk", rd_clk, 1);
    sw_clk = 1'b0; base_addr = 4'd11; cyc("R7 sw", 2);
    chk("R7", "brd_addr", brd_addr, 11);
    chk("R7", "busy", busy, 0);
    frame = 1'b0; hw_en = 1'b1; cyc("R7 back", 2);

    // R11: zero total
    total_bits = 16'd0; frame = 1'b1; cyc("R11 zero", 6);
    chk("R11", "busy", busy, 0);
    frame = 1'b0; cyc("R11 idle", 2);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule